// File: doc/BRIEF.md
# External interrupt flag controller

This block watches a set of asynchronous external interrupt pins and keeps one sticky flag per pin. Each pin first passes through a two-flop synchroniser. A channel then detects either a level or an edge, as its mode bit selects. A polarity bit picks the active level or the active edge. A pin-function enable gates whether the channel may set its flag at all.

Software uses a small register port with a write strobe, an address and write data. Read data is driven combinationally from the address. Four registers are visible: the flags, which are write-one-to-clear, and three configuration registers holding the mode, polarity and enable bits. A flag stays set until software clears it. In level mode a clear is refused while the pin is still at its active level. After changing a channel's mode or polarity, software is expected to clear that channel's flag.

Each channel drives one interrupt request. A single wake request goes to a power-down controller; while it is high, the next entry into power-down fails.

Top module: `xint_flag_ctrl`

## Requirements
- R1: After reset every flag, mode, polarity and enable bit reads 0, and every `irq_o` bit and `wake_o` are low.
- R2: Address 0 holds the flags, 1 the mode bits (0 = level, 1 = edge), 2 the polarity bits (0 = active low or falling edge, 1 = active high or rising edge), and 3 the enable bits. Channel i sits in data bit i. Bits 7:4 of every register read as 0, and the configuration registers read back what was last written to bits 3:0.
- R3: In level mode, with the channel enabled, a pin held at its active level sets the flag. The flag first reads 1 after the third rising clock edge from the cycle in which the pin changes.
- R4: In edge mode, with the channel enabled, the selected edge sets the flag, again visible after three rising edges. The opposite edge does not set it.
- R5: A channel whose enable bit is 0 never sets its flag, whatever its pin does.
- R6: Writing 1 to a bit at address 0 clears that flag. Writing 0 leaves the flag unchanged.
- R7: In level mode, a write-one clear has no effect while the synchronised pin is at its active level.
- R8: A set flag stays set when its pin returns to the inactive state, until a permitted clear.
- R9: When a set condition and a write-one clear of the same flag fall in the same cycle, the flag ends up set.
- R10: `irq_o[i]` is flag i ANDed with enable bit i. `wake_o` is high whenever any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, decoded combinationally from `reg_addr` |
| irq_o | output | 4 | Per-channel interrupt requests |
| wake_o | output | 1 | Combined flag request for the power-down controller |

## Verification
The hardest situation to bring about is the race where a set condition and a clear land in the same cycle. The clear must be written in exactly the cycle in which the delayed, synchronised edge reaches the detector, and that cycle comes three clock edges after the pin moves. A directed sequence counts those edges and writes the clear in that cycle. Long random runs then toggle pins and issue writes at random, so that clears collide with level holds and with edges, while a cycle-accurate model in the bench tracks the expected flags.

// File: rtl/xint_pkg.sv
package xint_pkg;
   localparam int XINT_REG_AW = 2;

   typedef enum logic [XINT_REG_AW-1:0] {
      XR_FLAGS = 2'd0,
      XR_MODE  = 2'd1,
      XR_POL   = 2'd2,
      XR_EN    = 2'd3
   } xint_reg_e;

   // Active-level test for one synchronised pin sample.
   function automatic logic pin_active(input logic smp, input logic pol);
      return ~(smp ^ pol);
   endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] dly_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xint_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];
   logic [W-1:0] dly_q;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= stage_q[STAGES-1];
   end

   assign sync_o = stage_q[STAGES-1];
   assign dly_o  = dly_q;
endmodule

// File: rtl/xint_chan.sv
module xint_chan
   import xint_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic smp_i,
   input  logic dly_i,
   input  logic mode_i,
   input  logic pol_i,
   input  logic en_i,
   input  logic clr_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;
   logic act;
   logic edge_hit;
   logic set_now;
   logic clr_ok;

   assign act      = pin_active(smp_i, pol_i);
   assign edge_hit = (smp_i ^ dly_i) & act;
   assign set_now  = en_i & (mode_i ? edge_hit : act);
   // A level-mode channel refuses a clear while its pin is still active.
   assign clr_ok   = clr_i & ~(~mode_i & act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_now) flag_q <= 1'b1;
      else if (clr_ok)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/xint_regs.sv
module xint_regs
   import xint_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 8,
   parameter int AW  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [NCH-1:0] flags_i,
   output logic [DW-1:0] rdata_o,
   output logic [NCH-1:0] clr_o,
   output logic [NCH-1:0] mode_o,
   output logic [NCH-1:0] pol_o,
   output logic [NCH-1:0] en_o
);
   localparam int PADW = DW - NCH;

   logic [NCH-1:0] mode_q, pol_q, en_q;
   logic           hit_flags, hit_mode, hit_pol, hit_en;
   logic           unused_wdata_hi;

   assign hit_flags = we_i && (addr_i == AW'(XR_FLAGS));
   assign hit_mode  = we_i && (addr_i == AW'(XR_MODE));
   assign hit_pol   = we_i && (addr_i == AW'(XR_POL));
   assign hit_en    = we_i && (addr_i == AW'(XR_EN));

   assign unused_wdata_hi = ^wdata_i[DW-1:NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pol_q  <= '0;
         en_q   <= '0;
      end else begin
         if (hit_mode) mode_q <= wdata_i[NCH-1:0];
         if (hit_pol)  pol_q  <= wdata_i[NCH-1:0];
         if (hit_en)   en_q   <= wdata_i[NCH-1:0];
      end
   end

   assign clr_o  = hit_flags ? wdata_i[NCH-1:0] : '0;
   assign mode_o = mode_q;
   assign pol_o  = pol_q;
   assign en_o   = en_q;

   always_comb begin
      rdata_o = '0;
      if      (addr_i == AW'(XR_FLAGS)) rdata_o = {{PADW{1'b0}}, flags_i};
      else if (addr_i == AW'(XR_MODE))  rdata_o = {{PADW{1'b0}}, mode_q};
      else if (addr_i == AW'(XR_POL))   rdata_o = {{PADW{1'b0}}, pol_q};
      else if (addr_i == AW'(XR_EN))    rdata_o = {{PADW{1'b0}}, en_q};
   end
endmodule

// File: rtl/xint_flag_ctrl.sv
module xint_flag_ctrl
   import xint_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] irq_o,
   output logic              wake_o
);
   if (NUM_CH >= DATA_W) begin : g_bad_width
      $error("xint_flag_ctrl: DATA_W must exceed NUM_CH");
   end
   if (ADDR_W != XINT_REG_AW) begin : g_bad_addr
      $error("xint_flag_ctrl: ADDR_W must match the register map");
   end

   logic [NUM_CH-1:0] smp_vec, dly_vec;
   logic [NUM_CH-1:0] mode_vec, pol_vec, en_vec, clr_vec;
   logic [NUM_CH-1:0] flag_vec;

   xint_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (smp_vec),
      .dly_o   (dly_vec)
   );

   xint_regs #(.NCH(NUM_CH), .DW(DATA_W), .AW(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .flags_i (flag_vec),
      .rdata_o (reg_rdata),
      .clr_o   (clr_vec),
      .mode_o  (mode_vec),
      .pol_o   (pol_vec),
      .en_o    (en_vec)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      xint_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .smp_i  (smp_vec[i]),
         .dly_i  (dly_vec[i]),
         .mode_i (mode_vec[i]),
         .pol_i  (pol_vec[i]),
         .en_i   (en_vec[i]),
         .clr_i  (clr_vec[i]),
         .flag_o (flag_vec[i]),
         .irq_o  (irq_o[i])
      );
   end

   assign wake_o = |flag_vec;
endmodule

// File: rtl/xint_flag_ctrl_chk.sv
module xint_flag_ctrl_chk #(
   parameter int NCH = 4,
   parameter int DW  = 8,
   parameter int AW  = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_we,
   input logic [AW-1:0]  reg_addr,
   input logic [DW-1:0]  reg_wdata,
   input logic [DW-1:0]  reg_rdata,
   input logic [NCH-1:0] irq_o,
   input logic           wake_o,
   input logic [NCH-1:0] flag_q,
   input logic [NCH-1:0] mode_q,
   input logic [NCH-1:0] pol_q,
   input logic [NCH-1:0] en_q,
   input logic [NCH-1:0] smp_q,
   input logic [NCH-1:0] dly_q
);
   logic flag_wr;
   assign flag_wr = reg_we && (reg_addr == '0);

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DW-1:NCH] == '0);

   assert_wake_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |-> wake_o);

   for (genvar i = 0; i < NCH; i++) begin : g_a
      assert_level_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[i] && !mode_q[i] && smp_q[i] == pol_q[i]) |=> flag_q[i]);

      assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[i] && mode_q[i] && smp_q[i] != dly_q[i] && smp_q[i] == pol_q[i])
         |=> flag_q[i]);

      assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_q[i] && !flag_q[i]) |=> !flag_q[i]);

      assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && reg_wdata[i] && mode_q[i] && smp_q[i] == dly_q[i])
         |=> !flag_q[i]);

      assert_clear_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !mode_q[i] && smp_q[i] == pol_q[i]) |=> flag_q[i]);

      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !(flag_wr && reg_wdata[i])) |=> flag_q[i]);

      assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[i] |-> (flag_q[i] && en_q[i]));
   end
endmodule

bind xint_flag_ctrl xint_flag_ctrl_chk #(.NCH(NUM_CH), .DW(DATA_W), .AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .wake_o    (wake_o),
   .flag_q    (flag_vec),
   .mode_q    (mode_vec),
   .pol_q     (pol_vec),
   .en_q      (en_vec),
   .smp_q     (smp_vec),
   .dly_q     (dly_vec)
);

// File: tb/xint_flag_ctrl_test.sv
module xint_flag_ctrl_test;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] pin_i;
   logic       reg_we;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [3:0] irq_o;
   logic       wake_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // reference model state
   logic [3:0] ms1, ms2, mp, mflag, mmode, mpol, men;
   logic [3:0] pv;

   always #(CLK_P/2) clk = ~clk;

   xint_flag_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .wake_o(wake_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model_rd(input logic [1:0] a);
      case (a)
         2'd0:    return {4'h0, mflag};
         2'd1:    return {4'h0, mmode};
         2'd2:    return {4'h0, mpol};
         default: return {4'h0, men};
      endcase
   endfunction

   task automatic model_step(input logic [3:0] pins, input logic we,
                             input logic [1:0] a, input logic [7:0] d);
      logic [3:0] lvl, edg, setv, clrv, blk;
      lvl  = ~(ms2 ^ mpol);
      edg  = (ms2 ^ mp) & lvl;
      setv = men & ((mmode & edg) | (~mmode & lvl));
      clrv = (we && a == 2'd0) ? d[3:0] : 4'h0;
      blk  = ~mmode & lvl;
      mflag = setv | (mflag & ~(clrv & ~blk));
      if (we && a == 2'd1) mmode = d[3:0];
      if (we && a == 2'd2) mpol  = d[3:0];
      if (we && a == 2'd3) men   = d[3:0];
      mp  = ms2;
      ms2 = ms1;
      ms1 = pins;
   endtask

   task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d);
      pin_i = pv; reg_we = we; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      model_step(pv, we, a, d);
      @(negedge clk);
      reg_we = 1'b0;
      chk("R10 irq", {28'h0, irq_o}, {28'h0, mflag & men});
      chk("R10 wake", {31'h0, wake_o}, {31'h0, |mflag});
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(1'b0, 2'd0, 8'h00);
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
      reg_we = 1'b0; reg_addr = a;
      #1;
      chk(req, {24'h0, reg_rdata}, {24'h0, exp});
      chk({req, " model"}, {24'h0, reg_rdata}, {24'h0, model_rd(a)});
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5EED_0017));
      pv = 4'hF; pin_i = pv; reg_we = 0; reg_addr = 0; reg_wdata = 0;
      rst_n = 1'b0;
      {ms1, ms2, mp, mflag, mmode, mpol, men} = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd("R1 flags", 2'd0, 8'h00);
      rd("R1 mode",  2'd1, 8'h00);
      rd("R1 pol",   2'd2, 8'h00);
      rd("R1 en",    2'd3, 8'h00);
      chk("R1 irq", {28'h0, irq_o}, 32'h0);
      chk("R1 wake", {31'h0, wake_o}, 32'h0);

      idle(3);
      cyc(1'b1, 2'd3, 8'h0F);
      rd("R2 en readback", 2'd3, 8'h0F);

      // R3 level low on ch0, three-edge latency
      pv[0] = 1'b0;
      idle(2);
      rd("R3 before latency", 2'd0, 8'h00);
      idle(1);
      rd("R3 level set", 2'd0, 8'h01);
      chk("R3 irq0", {28'h0, irq_o}, 32'h1);

      // R7 clear refused while active
      cyc(1'b1, 2'd0, 8'h01);
      rd("R7 clear blocked", 2'd0, 8'h01);

      // R8 sticky after pin release
      pv[0] = 1'b1;
      idle(4);
      rd("R8 sticky", 2'd0, 8'h01);

      // R6 write zero vs write one
      cyc(1'b1, 2'd0, 8'h00);
      rd("R6 zero no effect", 2'd0, 8'h01);
      cyc(1'b1, 2'd0, 8'h01);
      rd("R6 one clears", 2'd0, 8'h00);
      chk("R6 wake low", {31'h0, wake_o}, 32'h0);

      // R4 rising edge on ch1
      cyc(1'b1, 2'd1, 8'h02);
      cyc(1'b1, 2'd2, 8'h02);
      rd("R2 pol readback", 2'd2, 8'h02);
      pv[1] = 1'b0;
      idle(4);
      rd("R4 falling ignored", 2'd0, 8'h00);
      pv[1] = 1'b1;
      idle(2);
      rd("R4 before latency", 2'd0, 8'h00);
      idle(1);
      rd("R4 rising sets", 2'd0, 8'h02);

      // R10 flag held but enable off
      cyc(1'b1, 2'd3, 8'h0D);
      chk("R10 irq gated", {28'h0, irq_o}, 32'h0);
      chk("R10 wake held", {31'h0, wake_o}, 32'h1);

      // R5 disabled channel ignores edges
      cyc(1'b1, 2'd0, 8'h02);
      rd("R6 edge clear", 2'd0, 8'h00);
      pv[1] = 1'b0; idle(4);
      pv[1] = 1'b1; idle(4);
      rd("R5 disabled", 2'd0, 8'h00);
      cyc(1'b1, 2'd3, 8'h0F);

      // R9 set and clear in same cycle, ch3 falling edge
      cyc(1'b1, 2'd1, 8'h0A);
      cyc(1'b1, 2'd2, 8'h02);
      pv[3] = 1'b0;
      idle(2);
      cyc(1'b1, 2'd0, 8'h08);
      rd("R9 set wins", 2'd0, 8'h08);
      cyc(1'b1, 2'd0, 8'h08);
      rd("R6 later clear", 2'd0, 8'h00);

      // R2 reserved bits
      cyc(1'b1, 2'd1, 8'hFF);
      rd("R2 reserved mode", 2'd1, 8'h0F);
      cyc(1'b1, 2'd0, 8'hFF);
      rd("R2 reserved flags", 2'd0, model_rd(2'd0));

      // random phase
      for (int n = 0; n < 4000; n++) begin
         r = $urandom;
         pv = pv ^ (r[3:0] & r[7:4] & r[11:8]);
         cyc((r[15:13] == 3'd0), r[17:16], r[25:18]);
         if (n % 8 == 7)
            for (int a = 0; a < 4; a++) rd("R2 random read", 2'(a), model_rd(2'(a)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule